// File: doc/BRIEF.md
# Step-Sequenced Hardwired Control Unit

This block is the control unit of a small 16-bit processor built around three buses. A step counter moves through eight timing states, T0 to T7. In each state the unit combines that state with the decoded opcode, the source and destination addressing modes, the branch condition and the Negative and Zero flags. From these it drives every datapath strobe: register-file reads and writes, bus-A source, immediate injection, ALU function, memory read and write, the MAR, MDR, IR and STATUS loads, and program-counter increment, load, push and pop.

Every instruction opens with the same three-step fetch. Execution then takes between one and five more steps, depending on the opcode and the addressing modes. The unit raises a step-clear strobe in an instruction's last step, so the counter returns to T0 on the next edge and the next fetch starts at once. The datapath, the memory and the ALU are outside this block. The unit only needs the upper seven bits of the instruction register.

Top module: `step_ctrl_unit`

## Requirements
- R1: While `rst_n` is low, every control output is 0 and `step_oh` reads 8'b0000_0001. The reset acts asynchronously. After release, the first cycle is fetch step T0.
- R2: Fetch is the same for every instruction. T0 drives `bus_a_sel`=1 (PC), `alu_op`=0 (pass A) and `mar_load`. T1 drives `mem_rd`, `mdr_load` and `pc_inc`. T2 drives `ir_load` alone.
- R3: `step_oh` is one-hot with bit k set in step Tk. The step advances by one each clock. After a cycle with `step_clear` high, the next cycle is T0.
- R4: `ir_ctl` carries IR bits 15:9. The opcode is `ir_ctl[6:4]`, the source mode is `ir_ctl[3:2]`, the destination mode is `ir_ctl[1:0]`, and the branch condition is `ir_ctl[3:1]`. Modes are 0 register direct, 1 register indirect, 2 absolute and 3 immediate. Data opcodes map to `alu_op` as follows: 000 move→0 (pass A), 001→2 (add), 010→3 (sub), 011→4 (and), 100→5 (or), 101→6 (xor), 110 compare→3 (sub). Opcode 111 is the branch group.
- R5: With source mode 0 or 3, the ALU step is T3. It drives `rf_rd2`, `status_load` and the mapped `alu_op`. Mode 0 adds `rf_rd1` with `bus_a_sel`=2. Mode 3 adds `imm_sel`=1 (sign-extended value) with `bus_a_sel`=0.
- R6: With source mode 1 or 2, step T3 loads the MAR through pass A. Mode 1 takes the address from register port 1 (`rf_rd1`, `bus_a_sel`=2). Mode 2 takes it from the IR address field (`imm_sel`=2). T4 drives `mem_rd` and `mdr_load`. The ALU step is T5, with `bus_a_sel`=3 (MDR).
- R7: For a non-compare opcode with destination mode 0, the ALU step also drives `rf_wr` and `step_clear`.
- R8: For a non-compare opcode with destination mode 1 or 2, the ALU step also drives `mdr_load`. The next step loads the MAR. Mode 1 uses `rf_rd2` with `alu_op`=1 (pass B). Mode 2 uses `imm_sel`=2 with pass A. The step after that drives `mem_wr` and `step_clear`.
- R9: Compare, or destination mode 3, discards the result. The ALU step loads only STATUS and drives `step_clear`, with no register or memory write.
- R10: In the branch group, step T3 always drives `step_clear`. The branch is taken for condition 000 (always), 001 (N set), 010 (Z clear) and 011 (Z set). A taken branch drives `bus_a_sel`=1, `imm_sel`=3 (sign-extended offset onto B), `alu_op`=2 and `pc_load`. An untaken branch, or condition 110 or 111, drives nothing else.
- R11: Branch condition 100 is a call: a taken-branch step plus `pc_push`. Condition 101 is a return: `pc_pop` and `step_clear` only.
- R12: `mem_rd` and `mem_wr` are never high together. `pc_load` and `pc_pop` are never high together. No register or memory write occurs in T0 to T2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ir_ctl | input | 7 | Instruction register bits 15:9 |
| flag_n | input | 1 | Negative status flag |
| flag_z | input | 1 | Zero status flag |
| step_oh | output | 8 | One-hot current timing step |
| bus_a_sel | output | 2 | Bus A source: 0 none, 1 PC, 2 register port 1, 3 MDR |
| imm_sel | output | 2 | IR field injection: 0 none, 1 value, 2 address, 3 offset |
| alu_op | output | 3 | ALU function code |
| rf_rd1 | output | 1 | Register file read, port 1 |
| rf_rd2 | output | 1 | Register file read, port 2 (bus B) |
| rf_wr | output | 1 | Register file write |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| mar_load | output | 1 | Load memory address register |
| mdr_load | output | 1 | Load memory data register |
| ir_load | output | 1 | Load instruction register |
| status_load | output | 1 | Load N and Z flags |
| pc_inc | output | 1 | Increment program counter |
| pc_load | output | 1 | Load program counter from ALU |
| pc_push | output | 1 | Push program counter onto return stack |
| pc_pop | output | 1 | Pop program counter from return stack |
| step_clear | output | 1 | Last step; counter returns to T0 |

## Verification
The assertions check the step counter on every cycle: it stays one-hot, advances by one, and restarts after a clear. They also check the structural exclusions: no simultaneous memory read and write, no PC load during a pop, no writes or IR load outside their permitted fetch steps. Only the bench scenarios can show that each opcode and mode pairing produces the exact strobe set in the exact step. The same holds for whether the flags decide a branch correctly, and whether clear lands on the step that gives each instruction its length. The bench runs every data opcode against all sixteen mode pairs, every branch condition under all four flag combinations, and a reset asserted mid-instruction.

// File: rtl/ctl_pkg.sv
`timescale 1ns/1ps
package ctl_pkg;
    localparam int STEPS    = 8;
    localparam int STEP_W   = $clog2(STEPS);
    localparam int OP_W     = 3;
    localparam int MODE_W   = 2;
    localparam int COND_W   = 3;
    localparam int NUM_OP   = 1 << OP_W;
    localparam int NUM_MODE = 1 << MODE_W;
    localparam int NUM_COND = 1 << COND_W;
    localparam int IRC_W    = OP_W + 2 * MODE_W;

    typedef enum logic [1:0] {BA_NONE, BA_PC, BA_RF, BA_MDR} bus_a_e;
    typedef enum logic [1:0] {IM_NONE, IM_VALUE, IM_ADDR, IM_OFFSET} imm_e;
    typedef enum logic [2:0] {
        ALU_PASS_A, ALU_PASS_B, ALU_ADD, ALU_SUB,
        ALU_AND, ALU_OR, ALU_XOR, ALU_RSVD
    } alu_e;

    typedef struct packed {
        bus_a_e bus_a;
        imm_e   imm;
        alu_e   alu;
        logic   rf_rd1;
        logic   rf_rd2;
        logic   rf_wr;
        logic   mem_rd;
        logic   mem_wr;
        logic   mar_load;
        logic   mdr_load;
        logic   ir_load;
        logic   status_load;
        logic   pc_inc;
        logic   pc_load;
        logic   pc_push;
        logic   pc_pop;
        logic   step_clear;
    } ctrl_t;

    typedef struct packed {
        logic [STEP_W-1:0] step;
    } seq_state_t;
endpackage

// File: rtl/onehot_dec.sv
`timescale 1ns/1ps
module onehot_dec #(
    parameter int W = 3,
    localparam int N = 1 << W
) (
    input  logic [W-1:0] code,
    output logic [N-1:0] lines
);
    for (genvar g = 0; g < N; g++) begin : g_line
        assign lines[g] = (code == W'(g));
    end
endmodule

// File: rtl/step_seq.sv
`timescale 1ns/1ps
module step_seq
    import ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [STEPS-1:0] t
);
    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) st_d.step = '0;
        else     st_d.step = st_q.step + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    onehot_dec #(.W(STEP_W)) i_step_dec (.code(st_q.step), .lines(t));

    // R3: the step is always a single timing line
    assert_step_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(t));
    // R3: clear returns the counter to T0
    assert_clear_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.step == '0));
    // R3: without clear the counter advances by one
    assert_step_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (st_q.step == $past(st_q.step) + 1'b1));
endmodule

// File: rtl/ctrl_encoder.sv
`timescale 1ns/1ps
module ctrl_encoder
    import ctl_pkg::*;
(
    input  logic [STEPS-1:0]    t,
    input  logic [NUM_OP-1:0]   op,
    input  logic [NUM_MODE-1:0] sm,
    input  logic [NUM_MODE-1:0] dm,
    input  logic [NUM_COND-1:0] cm,
    input  logic                flag_n,
    input  logic                flag_z,
    output ctrl_t               ctrl
);
    logic is_data, src_mem, src_direct, is_cmp, keep, dst_mem;
    logic alu_stp, addr_stp, wr_stp, taken;
    alu_e fn;

    assign is_data    = ~op[7];
    assign src_mem    = sm[1] | sm[2];
    assign src_direct = sm[0] | sm[3];
    assign is_cmp     = op[6];
    assign keep       = ~is_cmp & ~dm[3];
    assign dst_mem    = dm[1] | dm[2];
    assign alu_stp    = (src_direct & t[3]) | (src_mem & t[5]);
    assign addr_stp   = (src_direct & t[4]) | (src_mem & t[6]);
    assign wr_stp     = (src_direct & t[5]) | (src_mem & t[7]);
    assign taken      = cm[0] | (cm[1] & flag_n) | (cm[2] & ~flag_z)
                      | (cm[3] & flag_z) | cm[4];

    always_comb begin
        if      (op[0]) fn = ALU_PASS_A;
        else if (op[1]) fn = ALU_ADD;
        else if (op[2]) fn = ALU_SUB;
        else if (op[3]) fn = ALU_AND;
        else if (op[4]) fn = ALU_OR;
        else if (op[5]) fn = ALU_XOR;
        else if (op[6]) fn = ALU_SUB;
        else            fn = ALU_PASS_A;
    end

    always_comb begin
        ctrl = '0;
        // common fetch
        if (t[0]) begin
            ctrl.bus_a    = BA_PC;
            ctrl.alu      = ALU_PASS_A;
            ctrl.mar_load = 1'b1;
        end
        if (t[1]) begin
            ctrl.mem_rd   = 1'b1;
            ctrl.mdr_load = 1'b1;
            ctrl.pc_inc   = 1'b1;
        end
        if (t[2]) ctrl.ir_load = 1'b1;

        if (is_data) begin
            // memory source operand: address then read
            if (src_mem & t[3]) begin
                ctrl.mar_load = 1'b1;
                ctrl.alu      = ALU_PASS_A;
                if (sm[1]) begin
                    ctrl.bus_a  = BA_RF;
                    ctrl.rf_rd1 = 1'b1;
                end else begin
                    ctrl.imm = IM_ADDR;
                end
            end
            if (src_mem & t[4]) begin
                ctrl.mem_rd   = 1'b1;
                ctrl.mdr_load = 1'b1;
            end
            // ALU step
            if (alu_stp) begin
                ctrl.rf_rd2      = 1'b1;
                ctrl.status_load = 1'b1;
                ctrl.alu         = fn;
                if (sm[0]) begin
                    ctrl.bus_a  = BA_RF;
                    ctrl.rf_rd1 = 1'b1;
                end else if (sm[3]) begin
                    ctrl.imm = IM_VALUE;
                end else begin
                    ctrl.bus_a = BA_MDR;
                end
                if (keep & dm[0]) begin
                    ctrl.rf_wr      = 1'b1;
                    ctrl.step_clear = 1'b1;
                end else if (keep & dst_mem) begin
                    ctrl.mdr_load = 1'b1;
                end else begin
                    ctrl.step_clear = 1'b1;
                end
            end
            // memory destination: address then write
            if (keep & dst_mem & addr_stp) begin
                ctrl.mar_load = 1'b1;
                if (dm[1]) begin
                    ctrl.rf_rd2 = 1'b1;
                    ctrl.alu    = ALU_PASS_B;
                end else begin
                    ctrl.imm = IM_ADDR;
                    ctrl.alu = ALU_PASS_A;
                end
            end
            if (keep & dst_mem & wr_stp) begin
                ctrl.mem_wr     = 1'b1;
                ctrl.step_clear = 1'b1;
            end
        end else if (t[3]) begin
            // branch group, single execute step
            ctrl.step_clear = 1'b1;
            if (cm[5]) begin
                ctrl.pc_pop = 1'b1;
            end else if (cm[6] | cm[7]) begin
                ctrl.step_clear = 1'b1;
            end else if (taken) begin
                ctrl.bus_a   = BA_PC;
                ctrl.imm     = IM_OFFSET;
                ctrl.alu     = ALU_ADD;
                ctrl.pc_load = 1'b1;
                ctrl.pc_push = cm[4];
            end
        end
    end
endmodule

// File: rtl/step_ctrl_unit.sv
`timescale 1ns/1ps
module step_ctrl_unit
    import ctl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IRC_W-1:0]     ir_ctl,
    input  logic                 flag_n,
    input  logic                 flag_z,
    output logic [STEPS-1:0]     step_oh,
    output logic [1:0]           bus_a_sel,
    output logic [1:0]           imm_sel,
    output logic [2:0]           alu_op,
    output logic                 rf_rd1,
    output logic                 rf_rd2,
    output logic                 rf_wr,
    output logic                 mem_rd,
    output logic                 mem_wr,
    output logic                 mar_load,
    output logic                 mdr_load,
    output logic                 ir_load,
    output logic                 status_load,
    output logic                 pc_inc,
    output logic                 pc_load,
    output logic                 pc_push,
    output logic                 pc_pop,
    output logic                 step_clear
);
    localparam int OP_LSB   = 2 * MODE_W;
    localparam int COND_LSB = IRC_W - OP_W - COND_W;

    logic [STEPS-1:0]    t;
    logic [NUM_OP-1:0]   op;
    logic [NUM_MODE-1:0] sm, dm;
    logic [NUM_COND-1:0] cm;
    ctrl_t               ctrl, ctrl_g;

    onehot_dec #(.W(OP_W))   i_op_dec  (.code(ir_ctl[OP_LSB +: OP_W]),     .lines(op));
    onehot_dec #(.W(MODE_W)) i_src_dec (.code(ir_ctl[MODE_W +: MODE_W]),   .lines(sm));
    onehot_dec #(.W(MODE_W)) i_dst_dec (.code(ir_ctl[0 +: MODE_W]),        .lines(dm));
    onehot_dec #(.W(COND_W)) i_cnd_dec (.code(ir_ctl[COND_LSB +: COND_W]), .lines(cm));

    step_seq i_seq (.clk(clk), .rst_n(rst_n), .clr(ctrl.step_clear), .t(t));

    ctrl_encoder i_enc (
        .t(t), .op(op), .sm(sm), .dm(dm), .cm(cm),
        .flag_n(flag_n), .flag_z(flag_z), .ctrl(ctrl)
    );

    assign ctrl_g      = rst_n ? ctrl : '0;
    assign step_oh     = t;
    assign bus_a_sel   = ctrl_g.bus_a;
    assign imm_sel     = ctrl_g.imm;
    assign alu_op      = ctrl_g.alu;
    assign rf_rd1      = ctrl_g.rf_rd1;
    assign rf_rd2      = ctrl_g.rf_rd2;
    assign rf_wr       = ctrl_g.rf_wr;
    assign mem_rd      = ctrl_g.mem_rd;
    assign mem_wr      = ctrl_g.mem_wr;
    assign mar_load    = ctrl_g.mar_load;
    assign mdr_load    = ctrl_g.mdr_load;
    assign ir_load     = ctrl_g.ir_load;
    assign status_load = ctrl_g.status_load;
    assign pc_inc      = ctrl_g.pc_inc;
    assign pc_load     = ctrl_g.pc_load;
    assign pc_push     = ctrl_g.pc_push;
    assign pc_pop      = ctrl_g.pc_pop;
    assign step_clear  = ctrl_g.step_clear;

    // R12: memory port is never driven both ways
    assert_mem_rw_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    // R12: a PC load and a stack pop never compete
    assert_pc_src_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(pc_load && pc_pop));
    // R12: no architectural write during fetch
    assert_fetch_no_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (step_oh[0] || step_oh[1] || step_oh[2]) |-> (!rf_wr && !mem_wr));
    // R2: the IR is only loaded in T2
    assert_ir_load_t2_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ir_load |-> step_oh[2]);
    // R2: the PC only increments in T1
    assert_pc_inc_t1_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pc_inc |-> step_oh[1]);
endmodule

// File: tb/test_step_ctrl_unit.sv
`timescale 1ns/1ps
module test_step_ctrl_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] ir_c = '0;
    logic       fn = 1'b0, fz = 1'b0;
    logic [7:0] step_oh;
    logic [1:0] bus_a_sel, imm_sel;
    logic [2:0] alu_op;
    logic rf_rd1, rf_rd2, rf_wr, mem_rd, mem_wr, mar_load, mdr_load, ir_load;
    logic status_load, pc_inc, pc_load, pc_push, pc_pop, step_clear;

    int tests = 0;
    int fails = 0;

    localparam logic [13:0] RD1 = 14'h2000, RD2 = 14'h1000, WR  = 14'h0800,
                            MRD = 14'h0400, MWR = 14'h0200, MAR = 14'h0100,
                            MDR = 14'h0080, IRL = 14'h0040, ST  = 14'h0020,
                            INC = 14'h0010, PCL = 14'h0008, PSH = 14'h0004,
                            POP = 14'h0002, CLR = 14'h0001;

    logic [20:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    step_ctrl_unit i_step_ctrl_unit (
        .clk(clk), .rst_n(rst_n), .ir_ctl(ir_c), .flag_n(fn), .flag_z(fz),
        .step_oh(step_oh), .bus_a_sel(bus_a_sel), .imm_sel(imm_sel), .alu_op(alu_op),
        .rf_rd1(rf_rd1), .rf_rd2(rf_rd2), .rf_wr(rf_wr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mar_load(mar_load), .mdr_load(mdr_load), .ir_load(ir_load),
        .status_load(status_load), .pc_inc(pc_inc), .pc_load(pc_load),
        .pc_push(pc_push), .pc_pop(pc_pop), .step_clear(step_clear)
    );

    function automatic logic [20:0] actual();
        return {bus_a_sel, imm_sel, alu_op, rf_rd1, rf_rd2, rf_wr, mem_rd, mem_wr,
                mar_load, mdr_load, ir_load, status_load, pc_inc, pc_load,
                pc_push, pc_pop, step_clear};
    endfunction

    function automatic logic [20:0] v(input int a, input int im, input int alu,
                                      input logic [13:0] f);
        return {a[1:0], im[1:0], alu[2:0], f};
    endfunction

    task automatic push(input logic [20:0] e, input string tg);
        exp_q.push_back(e);
        tag_q.push_back(tg);
    endtask

    // Reference plan per instruction, built from the requirement text
    task automatic build_plan(input logic [6:0] irc, input logic n, input logic z);
        int op, sm, dm, cond, fnc, a, im;
        bit tk, cmp;
        logic [13:0] f;
        string tg;
        push(v(1, 0, 0, MAR), "R2 R12");
        push(v(0, 0, 0, MRD | MDR | INC), "R2 R12");
        push(v(0, 0, 0, IRL), "R2 R12");
        op = int'(irc[6:4]);
        if (op == 7) begin
            cond = int'(irc[3:1]);
            tk = (cond == 0) || (cond == 1 && n) || (cond == 2 && !z) ||
                 (cond == 3 && z) || (cond == 4);
            if (cond == 5)      push(v(0, 0, 0, POP | CLR), "R11");
            else if (cond == 4) push(v(1, 3, 2, PCL | PSH | CLR), "R11");
            else if (tk)        push(v(1, 3, 2, PCL | CLR), "R10");
            else                push(v(0, 0, 0, CLR), "R10");
        end else begin
            sm = int'(irc[3:2]);
            dm = int'(irc[1:0]);
            cmp = (op == 6);
            fnc = (op == 0) ? 0 : (op == 6) ? 3 : op + 1;
            if (sm == 1 || sm == 2) begin
                push((sm == 1) ? v(2, 0, 0, RD1 | MAR) : v(0, 2, 0, MAR), "R6");
                push(v(0, 0, 0, MRD | MDR), "R6");
            end
            a  = (sm == 0) ? 2 : (sm == 3) ? 0 : 3;
            im = (sm == 3) ? 1 : 0;
            f  = RD2 | ST | ((sm == 0) ? RD1 : 14'h0);
            tg = (sm == 1 || sm == 2) ? "R6 R4" : "R5 R4";
            if (!cmp && dm == 0) begin
                f |= WR | CLR; tg = {tg, " R7"};
            end else if (!cmp && (dm == 1 || dm == 2)) begin
                f |= MDR; tg = {tg, " R8"};
            end else begin
                f |= CLR; tg = {tg, " R9"};
            end
            push(v(a, im, fnc, f), tg);
            if (!cmp && (dm == 1 || dm == 2)) begin
                push((dm == 1) ? v(0, 0, 1, RD2 | MAR) : v(0, 2, 0, MAR), "R8");
                push(v(0, 0, 0, MWR | CLR), "R8");
            end
        end
    endtask

    task automatic check_vec(input logic [20:0] e, input string tg, input int k);
        tests++;
        if (actual() !== e) begin
            fails++;
            $display("FAIL %s ir=%b step T%0d: actual %b expected %b",
                     tg, ir_c, k, actual(), e);
        end
    endtask

    task automatic check_step(input int k);
        logic [7:0] e;
        e = 8'(1 << k);
        tests++;
        if (step_oh !== e) begin
            fails++;
            $display("FAIL R3 ir=%b step: actual %b expected %b", ir_c, step_oh, e);
        end
    endtask

    task automatic check_reset();
        tests++;
        if (actual() !== 21'h0 || step_oh !== 8'b1) begin
            fails++;
            $display("FAIL R1 reset: actual ctrl %b step %b expected ctrl 0 step 00000001",
                     actual(), step_oh);
        end
    endtask

    task automatic run_instr(input logic [6:0] irc, input logic n, input logic z,
                             input int abort_at);
        int k;
        logic [20:0] e;
        string tg;
        k = 0;
        exp_q.delete();
        tag_q.delete();
        build_plan(irc, n, z);
        @(negedge clk);
        ir_c = irc; fn = n; fz = z;
        #1;
        while (exp_q.size() > 0) begin
            if (k > 0) begin
                @(negedge clk);
                #1;
            end
            e  = exp_q.pop_front();
            tg = tag_q.pop_front();
            check_vec(e, tg, k);
            check_step(k);
            if (k == abort_at) begin
                rst_n = 1'b0;   // R1: asynchronous reset mid-instruction
                #1;
                check_reset();
                @(posedge clk);
                #1;
                rst_n = 1'b1;
                return;
            end
            k++;
        end
    endtask

    initial begin
        #(5.0 * 20000);
        fails++;
        $display("FAIL R3 watchdog: actual still running expected finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1;
        check_reset();              // R1 reset state
        @(posedge clk);
        #1;
        check_reset();
        rst_n = 1'b1;
        // R4..R9: every data opcode against every mode pair
        for (int op = 0; op < 7; op++) begin
            for (int sm = 0; sm < 4; sm++) begin
                for (int dm = 0; dm < 4; dm++) begin
                    run_instr({op[2:0], sm[1:0], dm[1:0]}, op[0], sm[0], -1);
                end
            end
        end
        // R10, R11: every branch condition under every flag pair
        for (int c = 0; c < 8; c++) begin
            for (int nz = 0; nz < 4; nz++) begin
                run_instr({3'b111, c[2:0], nz[0]}, nz[1], nz[0], -1);
            end
        end
        // R1: reset in the middle of a long instruction, then a clean restart
        run_instr(7'b001_01_01, 1'b0, 1'b0, 4);
        run_instr(7'b000_11_00, 1'b0, 1'b0, -1);
        run_instr(7'b010_10_10, 1'b1, 1'b1, 1);
        run_instr(7'b111_010_0, 1'b0, 1'b0, -1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule